// File: doc/BRIEF.md
# System Clock Source Switch with Fail Detection

This block picks the source of the system clock from five candidates: a high-speed crystal, a low-speed crystal, the PLL, a low-speed internal oscillator and a high-speed internal oscillator. Each source reaches the block as a tick input in one reference clock domain, and each also has a stable flag. The block turns the ticks of the selected source into an output clock-enable pulse train that is divided by a 4-bit divide value.

Software drives a byte-wide register bus. The select field is write protected. It opens only after a three-byte key has been written to the lock register. A switch request to a source that is not yet stable is refused, and a sticky fail flag records the refusal. On every reset the select field reloads from a 3-bit configuration input, so the chip can boot from either of the high-speed sources.

Register layout on `bus_addr`:
- Address 0 is the lock register. A write feeds the key sequence, and a read returns the open state in bit 0.
- Address 1 is the select register, `[2:0]`.
- Address 2 is the divide value, `[3:0]`.
- Address 3 is the status register. Bits `[4:0]` hold the stable flags and bit 7 holds the fail flag.

Top module: `hclk_source_switch`

## Requirements
- R1: On reset the select field loads `cfg_sel` when that value is a valid code, and 000 otherwise. At the same time the fail flag clears, the lock closes (address 0 reads 0), the divide value clears and `hclk_en` is 0.
- R2: The select codes map to source indexes as follows: 000 is index 0 (high-speed crystal), 001 is index 1 (low-speed crystal), 010 is index 2 (PLL), 011 is index 3 (low-speed internal oscillator) and 111 is index 4 (high-speed internal oscillator). Only ticks on `src_tick[index]` of the selected source advance the output divider.
- R3: `hclk_en` pulses for one cycle on every (N+1)th tick of the selected source, where N is the divide value. The pulse appears one cycle after the tick that completes the count. An accepted select write or a divide write restarts the count.
- R4: Writing 0x59, then 0x16, then 0x88 to address 0 opens write protection. Address 0 then reads 1 in bit 0.
- R5: A wrong byte at any step of the key returns the sequence to its start. While protection is open, writing 0x00 to address 0 closes it, and any other byte leaves it open.
- R6: A select write while protection is closed leaves both the select field and the fail flag unchanged.
- R7: An open select write of a valid code whose source has its stable flag at 1 switches to that source and clears the fail flag.
- R8: An open select write of a valid code whose source is not stable keeps the previous selection and sets the fail flag.
- R9: A select write of a reserved code (100, 101 or 110) is ignored. The select field and the fail flag are unchanged.
- R10: Writing address 3 with bit 7 at 1 clears the fail flag. With bit 7 at 0 the write has no effect on the fail flag.
- R11: Address 3 bits `[4:0]` read `src_stable` by source index, and writes to address 3 do not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 3 | Select value loaded on reset |
| src_tick | input | 5 | One tick per source clock edge, by source index |
| src_stable | input | 5 | Stable flag per source, by source index |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| hclk_en | output | 1 | Divided system clock-enable pulse |

## Verification
A wrong lock state shows up on the next read of address 0. It also shows up on the next select write, which then switches or fails to switch against expectation. A wrong select or fail value is visible on the read that follows the write. A divider counter that slips is exposed within one pass of N+1 ticks, as a pulse count off by one. Ticks on the sources that are not selected must produce no pulse at all.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int NSRC   = 5;
  localparam int SEL_W  = 3;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_LOCK   = 2'd0;
  localparam logic [ADDR_W-1:0] A_SELECT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIVIDE = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

  localparam logic [DATA_W-1:0] KEY_A = 8'h59;
  localparam logic [DATA_W-1:0] KEY_B = 8'h16;
  localparam logic [DATA_W-1:0] KEY_C = 8'h88;
  localparam logic [DATA_W-1:0] KEY_CLOSE = 8'h00;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_GOT_A = 2'd1,
    LK_GOT_B = 2'd2,
    LK_OPEN = 2'd3
  } lock_state_e;

  // Codes 100..110 are reserved.
  function automatic logic code_valid(input logic [SEL_W-1:0] c);
    return (c[2] == 1'b0) || (c == 3'b111);
  endfunction

  function automatic logic [IDX_W-1:0] code_to_idx(input logic [SEL_W-1:0] c);
    logic [IDX_W-1:0] r;
    case (c)
      3'b000:  r = 3'd0;
      3'b001:  r = 3'd1;
      3'b010:  r = 3'd2;
      3'b011:  r = 3'd3;
      3'b111:  r = 3'd4;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

  function automatic logic [SEL_W-1:0] reset_code(input logic [SEL_W-1:0] c);
    return code_valid(c) ? c : 3'b000;
  endfunction

  function automatic lock_state_e lock_next(input lock_state_e s,
                                            input logic [DATA_W-1:0] b);
    lock_state_e n;
    case (s)
      LK_IDLE:  n = (b == KEY_A) ? LK_GOT_A : LK_IDLE;
      LK_GOT_A: n = (b == KEY_B) ? LK_GOT_B : LK_IDLE;
      LK_GOT_B: n = (b == KEY_C) ? LK_OPEN  : LK_IDLE;
      default:  n = (b == KEY_CLOSE) ? LK_IDLE : LK_OPEN;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/hcs_unlock.sv
module hcs_unlock
  import hcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [DATA_W-1:0] key_byte,
  output logic              unlocked
);
  lock_state_e state_q;
  lock_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (key_we) state_d = lock_next(state_q, key_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_IDLE;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == LK_OPEN);

  // R4
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_we && (key_byte == KEY_C)));

  // R5
  relock_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_we && (key_byte == KEY_CLOSE)) |=> !unlocked);

  // R5
  open_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !(key_we && (key_byte == KEY_CLOSE))) |=> unlocked);
endmodule

// File: rtl/hcs_selreg.sv
module hcs_selreg
  import hcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             unlocked,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [NSRC-1:0]  stable,
  input  logic             fail_clr,
  output logic [SEL_W-1:0] sel_q,
  output logic [IDX_W-1:0] sel_idx,
  output logic             fail_q,
  output logic             switch_done
);
  logic attempt;
  logic tgt_stable;
  logic refused;

  assign attempt     = sel_we && unlocked && code_valid(sel_wdata);
  assign tgt_stable  = stable[code_to_idx(sel_wdata)];
  assign switch_done = attempt && tgt_stable;
  assign refused     = attempt && !tgt_stable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sel_q <= reset_code(cfg_sel);
    else if (switch_done) sel_q <= sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fail_q <= 1'b0;
    else if (refused)     fail_q <= 1'b1;
    else if (switch_done) fail_q <= 1'b0;
    else if (fail_clr)    fail_q <= 1'b0;
  end

  assign sel_idx = code_to_idx(sel_q);

  // R6
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && !unlocked) |=> ($stable(sel_q) && $stable(fail_q)));

  // R7
  switch_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt && tgt_stable) |=> ((sel_q == $past(sel_wdata)) && !fail_q));

  // R8
  switch_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt && !tgt_stable) |=> (fail_q && $stable(sel_q)));

  // R9
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && !code_valid(sel_wdata)) |=> ($stable(sel_q) && $stable(fail_q)));

  // R10
  fail_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_clr && !sel_we) |=> !fail_q);
endmodule

// File: rtl/hcs_divider.sv
module hcs_divider
  import hcs_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  tick_vec,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [DIV_W-1:0] div_n,
  input  logic             restart,
  output logic             en
);
  logic [DIV_W-1:0] cnt_q;
  logic             sel_tick;
  logic             wrap;

  assign sel_tick = tick_vec[src_idx];
  assign wrap     = sel_tick && (cnt_q == div_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (wrap)     cnt_q <= '0;
    else if (sel_tick) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= wrap && !restart;
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_n);

  // R2
  en_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $past(sel_tick));

  // R3
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (div_n != '0)) |=> !en);
endmodule

// File: rtl/hclk_source_switch.sv
module hclk_source_switch
  import hcs_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [NSRC-1:0]   src_tick,
  input  logic [NSRC-1:0]   src_stable,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              hclk_en
);
  logic             we_lock;
  logic             we_sel;
  logic             we_div;
  logic             we_stat;
  logic             unlocked;
  logic [SEL_W-1:0] sel_q;
  logic [IDX_W-1:0] sel_idx;
  logic             fail_q;
  logic             switch_done;
  logic [DIV_W-1:0] div_q;
  logic             restart;

  assign we_lock = bus_we && (bus_addr == A_LOCK);
  assign we_sel  = bus_we && (bus_addr == A_SELECT);
  assign we_div  = bus_we && (bus_addr == A_DIVIDE);
  assign we_stat = bus_we && (bus_addr == A_STATUS);

  hcs_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (we_lock),
    .key_byte (bus_wdata),
    .unlocked (unlocked)
  );

  hcs_selreg u_selreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sel     (cfg_sel),
    .unlocked    (unlocked),
    .sel_we      (we_sel),
    .sel_wdata   (bus_wdata[SEL_W-1:0]),
    .stable      (src_stable),
    .fail_clr    (we_stat && bus_wdata[DATA_W-1]),
    .sel_q       (sel_q),
    .sel_idx     (sel_idx),
    .fail_q      (fail_q),
    .switch_done (switch_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (we_div) div_q <= bus_wdata[DIV_W-1:0];
  end

  assign restart = switch_done || we_div;

  hcs_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_vec (src_tick),
    .src_idx  (sel_idx),
    .div_n    (div_q),
    .restart  (restart),
    .en       (hclk_en)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LOCK:   bus_rdata[0] = unlocked;
      A_SELECT: bus_rdata[SEL_W-1:0] = sel_q;
      A_DIVIDE: bus_rdata[DIV_W-1:0] = div_q;
      default: begin
        bus_rdata[NSRC-1:0]   = src_stable;
        bus_rdata[DATA_W-1]   = fail_q;
      end
    endcase
  end

  // R9
  sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid(sel_q));
endmodule

// File: tb/hclk_source_switch_tb_top.sv
module hclk_source_switch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_sel = 3'b111;
  logic [4:0] src_tick = '0;
  logic [4:0] src_stable = '0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       hclk_en;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 0;

  int       m_prog;
  bit [2:0] m_sel;
  bit       m_fail;
  bit [3:0] m_div;

  always #4 clk = ~clk;

  hclk_source_switch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .src_tick(src_tick),
    .src_stable(src_stable), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hclk_en(hclk_en)
  );

  always @(negedge clk) if (hclk_en) pulses++;

  function automatic bit legal(bit [2:0] c);
    return !(c == 3'd4 || c == 3'd5 || c == 3'd6);
  endfunction

  function automatic int index_of(bit [2:0] c);
    return (c == 3'd7) ? 4 : int'(c);
  endfunction

  function automatic bit [7:0] key_at(int p);
    case (p)
      0: return 8'h59;
      1: return 8'h16;
      default: return 8'h88;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit [1:0] a, bit [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      2'd0: begin
        if (m_prog == 3) m_prog = (d == 8'h00) ? 0 : 3;
        else if (d == key_at(m_prog)) m_prog++;
        else m_prog = 0;
      end
      2'd1: if (m_prog == 3 && legal(d[2:0])) begin
        if (src_stable[index_of(d[2:0])]) begin m_sel = d[2:0]; m_fail = 0; end
        else m_fail = 1;
      end
      2'd2: m_div = d[3:0];
      default: if (d[7]) m_fail = 0;
    endcase
  endtask

  task automatic rd(bit [1:0] a, output bit [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check_state(string req);
    bit [7:0] d;
    rd(2'd0, d); check({req, " lock"}, d, (m_prog == 3) ? 1 : 0);
    rd(2'd1, d); check({req, " select"}, d, m_sel);
    rd(2'd3, d); check({req, " status"}, d, {m_fail, 2'b00, src_stable});
  endtask

  task automatic do_reset(bit [2:0] cfg);
    bit [7:0] d;
    @(negedge clk);
    rst_n = 1'b0; cfg_sel = cfg;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_prog = 0; m_fail = 0; m_div = 0;
    m_sel = legal(cfg) ? cfg : 3'b000;
    check_state("R1");
    rd(2'd2, d); check("R1 divide", d, 0);
    check("R1 hclk_en", hclk_en, 0);
  endtask

  task automatic open_lock();
    wr(2'd0, 8'h59); wr(2'd0, 8'h16); wr(2'd0, 8'h88);
  endtask

  // One tick on source idx plus noise on the others.
  task automatic tick_src(int idx, bit noise);
    @(negedge clk);
    src_tick = (5'b1 << idx) | (noise ? (5'($urandom) & ~(5'b1 << idx)) : 5'b0);
    @(negedge clk);
    src_tick = '0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic div_case(bit [2:0] code, bit [3:0] n, int k);
    int idx;
    idx = index_of(code);
    src_stable = 5'b11111;
    open_lock();
    wr(2'd1, {5'b0, code});
    wr(2'd2, {4'b0, n});
    @(negedge clk); #1 pulses = 0;
    for (int i = 0; i < k; i++) tick_src(idx, 1'b1);
    repeat (2) @(negedge clk);
    #1 check($sformatf("R3 src%0d n=%0d k=%0d pulses", idx, n, k), pulses, k / (int'(n) + 1));
    // Ticks on other sources only must not advance the divider.
    wr(2'd2, {4'b0, n});
    @(negedge clk); #1 pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      src_tick = 5'b11111 & ~(5'b1 << idx);
    end
    @(negedge clk); src_tick = '0;
    repeat (2) @(negedge clk);
    #1 check($sformatf("R2 src%0d unselected ticks", idx), pulses, 0);
  endtask

  initial begin
    bit [7:0] d;
    void'($urandom(32'h5EED_1234));
    m_prog = 0; m_sel = 3'b111; m_fail = 0; m_div = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_state("R1");
    check("R1 hclk_en", hclk_en, 0);

    // R6: locked write ignored
    src_stable = 5'b11111;
    wr(2'd1, 8'h01); check_state("R6");
    // R4: key opens
    open_lock(); check_state("R4");
    // R7: stable target accepted
    wr(2'd1, 8'h02); check_state("R7");
    // R8: unstable target refused
    src_stable = 5'b10111;
    wr(2'd1, 8'h03); check_state("R8");
    // R10: bit 7 clear has no effect, bit 7 set clears
    wr(2'd3, 8'h1F); check_state("R10");
    rd(2'd3, d); check("R11 stable after write", d[4:0], 5'b10111);
    wr(2'd3, 8'h80); check_state("R10");
    // R9: reserved codes ignored
    wr(2'd1, 8'h03); wr(2'd1, 8'h05); check_state("R9");
    wr(2'd1, 8'h04); wr(2'd1, 8'h06); check_state("R9");
    // R5: stays open on nonzero, closes on zero, bad step restarts
    wr(2'd0, 8'h59); check_state("R5");
    wr(2'd0, 8'h00); check_state("R5");
    wr(2'd0, 8'h59); wr(2'd0, 8'h59); wr(2'd0, 8'h16); wr(2'd0, 8'h88);
    check_state("R5");
    wr(2'd0, 8'h59); wr(2'd0, 8'h16); wr(2'd0, 8'h00); wr(2'd0, 8'h88);
    check_state("R5");

    // Reset reloads
    do_reset(3'b000);
    do_reset(3'b101);
    do_reset(3'b111);

    // Divider, directed corners then random
    div_case(3'b000, 4'd0, 7);
    div_case(3'b111, 4'd15, 40);
    div_case(3'b001, 4'd3, 17);
    div_case(3'b010, 4'd1, 9);
    div_case(3'b011, 4'd2, 12);
    for (int i = 0; i < 10; i++) begin
      bit [2:0] c;
      c = 3'($urandom);
      if (!legal(c)) c = 3'b111;
      div_case(c, 4'($urandom), 10 + ($urandom % 40));
    end

    // Random register traffic
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 7)
        0: begin
          for (int p = 0; p < 3; p++)
            wr(2'd0, ($urandom % 8 == 0) ? 8'($urandom) : key_at(p));
        end
        1: wr(2'd0, 8'h00);
        2: wr(2'd0, 8'($urandom));
        3: wr(2'd1, 8'($urandom));
        4: wr(2'd3, 8'($urandom));
        5: begin @(negedge clk); src_stable = 5'($urandom); end
        default: wr(2'd2, 8'($urandom));
      endcase
      check_state("R4/R5/R6/R7/R8/R9/R10/R11 random");
    end
    rd(2'd2, d); check("R3 divide readback", d, m_div);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule